// File: doc/BRIEF.md
# Byte-Lane Flash Program and Erase Controller

This controller sits between a simple request port and a 32-bit flash array made of four byte-wide dies. The dies share the address lines and the output enable; each byte lane has its own chip select and write enable. A request names one of five operations: word read, word program, single-byte program, sector erase or whole-array erase. For a program or an erase the controller plays the fixed unlock write sequence on the asynchronous bus and strobes only the lanes that the operation touches. It then reads the array repeatedly until bit 7 of every selected lane shows its final value. It reports completion, and an error if a poll budget runs out.

All bus timing is set by parameters counted in clock cycles: the setup before a write pulse, the pulse width, the hold after it, the quiet time on output enable before polling, and the access time of a read. The state machine has nine states. S_IDLE accepts a request. S_CMD_SET, S_CMD_PULSE and S_CMD_HOLD form one write cycle and repeat for each step of the sequence. S_OE_GAP waits out the output-enable recovery. S_POLL_ACC and S_POLL_CHK alternate to read and judge the status. S_READ_ACC performs a plain read. S_REPORT raises the done pulse.

The transitions are as follows. S_IDLE goes to S_READ_ACC for a read and to S_CMD_SET for any other operation. S_CMD_SET goes to S_CMD_PULSE, and S_CMD_PULSE goes to S_CMD_HOLD. S_CMD_HOLD goes back to S_CMD_SET when more steps remain, and to S_OE_GAP after the last step. S_OE_GAP goes to S_POLL_ACC, and S_POLL_ACC goes to S_POLL_CHK. S_POLL_CHK goes to S_REPORT on success or when the budget is spent, and back to S_POLL_ACC otherwise. S_READ_ACC goes to S_REPORT, and S_REPORT returns to S_IDLE. Each timed state lasts exactly its parameter in cycles.

Top module: `flash_pe_ctrl`

## Requirements
- R1: After reset the controller is idle: `req_ready`=1, all chip selects, write enables and output enable high (inactive), `rsp_done`=0.
- R2: Word program (`req_op`=1) writes, on all four lanes, AAh at 5555h, then 55h at 2AAAh, then A0h at 5555h, then the data at `req_addr`. Lane k carries `req_wdata[8k+7:8k]` in the data cycle and the command byte in the others.
- R3: Byte program (`req_op`=2) runs the R2 sequence only on lane `req_lane` (lane k = data bits 8k+7..8k), using that lane's byte of `req_wdata`. The chip select and write enable of every other lane stay high, and their stored bytes are unchanged.
- R4: Sector erase (`req_op`=3) writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 30h@`req_addr` on all lanes. Array erase (`req_op`=4) writes the same first five cycles and ends with 10h@5555h.
- R5: Each write enable pulse lasts exactly T_WP cycles, with the lane's chip select low. Address and data are stable during the pulse, for at least T_SET cycles before it and for at least T_HOLD cycles after it.
- R6: After the last write of a sequence, output enable stays high with all chip selects high for at least T_OEH cycles before the first status read.
- R7: Polling succeeds when bit 7 of every selected lane equals the expected value: the written data bit 7 for a program, 1 for an erase. One lane still busy keeps the operation from succeeding. Success gives `rsp_done`=1 with `rsp_fail`=0.
- R8: If POLL_MAX status reads pass without success, the controller ends with `rsp_done`=1 and `rsp_fail`=1, having made exactly POLL_MAX reads.
- R9: Every read, whether a status read or a word read (`req_op`=0, all lanes selected), holds output enable low for exactly T_ACC cycles. A word read returns the sampled bus word on `rsp_rdata` with `rsp_fail`=0.
- R10: `req_ready` is high only while idle, and a request presented while busy is ignored. `rsp_done` is a single-cycle pulse.
- R11: The controller never drives the data bus while output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken this cycle |
| req_op | input | 3 | 0 read, 1 word program, 2 byte program, 3 sector erase, 4 array erase |
| req_addr | input | ADDR_W | Word address (sector address for sector erase) |
| req_lane | input | LANE_W | Lane for byte program |
| req_wdata | input | 8*LANES | Program data |
| rsp_done | output | 1 | Operation finished (one cycle) |
| rsp_fail | output | 1 | Poll budget exhausted, valid with rsp_done |
| rsp_rdata | output | 8*LANES | Last sampled bus word |
| fl_addr | output | ADDR_W | Shared array address |
| fl_dout | output | 8*LANES | Write data to the array |
| fl_dout_en | output | 1 | Data bus driven by controller |
| fl_din | input | 8*LANES | Read data from the array |
| fl_cs_n | output | LANES | Per-lane chip select, active low |
| fl_we_n | output | LANES | Per-lane write enable, active low |
| fl_oe_n | output | 1 | Shared output enable, active low |

## Verification
The bench pairs the controller with a behavioural byte-lane array that checks each unlock sequence step by step. A wrong address, byte or step order shows up as protocol errors and as data that was never stored. Byte programs on each lane leave a zero pattern on the other lanes, so a controller that strobes extra lanes corrupts the readback. A permanently busy array and a single stuck lane exercise the poll budget; an early success or an off-by-one budget changes the counted status reads. A request held during a busy operation is an array erase, so accepting it would wipe data that the bench later reads back.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;

    typedef enum logic [2:0] {
        OP_READ       = 3'd0,
        OP_PROG_WORD  = 3'd1,
        OP_PROG_BYTE  = 3'd2,
        OP_ERASE_SECT = 3'd3,
        OP_ERASE_CHIP = 3'd4
    } fop_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CMD_SET,
        S_CMD_PULSE,
        S_CMD_HOLD,
        S_OE_GAP,
        S_POLL_ACC,
        S_POLL_CHK,
        S_READ_ACC,
        S_REPORT
    } fstate_e;

    localparam logic [15:0] UNLK_ADDR_A = 16'h5555;
    localparam logic [15:0] UNLK_ADDR_B = 16'h2AAA;
    localparam logic [7:0]  UNLK_BYTE_A = 8'hAA;
    localparam logic [7:0]  UNLK_BYTE_B = 8'h55;
    localparam logic [7:0]  CMD_PROG    = 8'hA0;
    localparam logic [7:0]  CMD_ERASE   = 8'h80;
    localparam logic [7:0]  CMD_SECT    = 8'h30;
    localparam logic [7:0]  CMD_CHIP    = 8'h10;

endpackage

// File: rtl/fl_cmd_table.sv
module fl_cmd_table
    import flash_pe_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int LANES  = 4
) (
    input  fop_e                   op,
    input  logic [2:0]             step,
    input  logic [ADDR_W-1:0]      tgt_addr,
    input  logic [8*LANES-1:0]     wdata,
    output logic [ADDR_W-1:0]      bus_addr,
    output logic [8*LANES-1:0]     bus_data,
    output logic                   last
);
    logic is_erase;
    logic is_chip;

    assign is_erase = (op == OP_ERASE_SECT) || (op == OP_ERASE_CHIP);
    assign is_chip  = (op == OP_ERASE_CHIP);

    always_comb begin
        bus_addr = ADDR_W'(UNLK_ADDR_A);
        bus_data = {LANES{UNLK_BYTE_A}};
        last     = 1'b0;
        unique case (step)
            3'd0: begin
                bus_addr = ADDR_W'(UNLK_ADDR_A);
                bus_data = {LANES{UNLK_BYTE_A}};
            end
            3'd1, 3'd4: begin
                bus_addr = ADDR_W'(UNLK_ADDR_B);
                bus_data = {LANES{UNLK_BYTE_B}};
            end
            3'd2: begin
                bus_addr = ADDR_W'(UNLK_ADDR_A);
                bus_data = is_erase ? {LANES{CMD_ERASE}} : {LANES{CMD_PROG}};
            end
            3'd3: begin
                if (is_erase) begin
                    bus_addr = ADDR_W'(UNLK_ADDR_A);
                    bus_data = {LANES{UNLK_BYTE_A}};
                end else begin
                    bus_addr = tgt_addr;
                    bus_data = wdata;
                    last     = 1'b1;
                end
            end
            default: begin
                last = 1'b1;
                if (is_chip) begin
                    bus_addr = ADDR_W'(UNLK_ADDR_A);
                    bus_data = {LANES{CMD_CHIP}};
                end else begin
                    bus_addr = tgt_addr;
                    bus_data = {LANES{CMD_SECT}};
                end
            end
        endcase
    end
endmodule

// File: rtl/fl_lane_status.sv
module fl_lane_status #(
    parameter int LANES = 4
) (
    input  logic [8*LANES-1:0] rd_word,
    input  logic [LANES-1:0]   sel,
    input  logic [LANES-1:0]   want7,
    output logic               all_ok
);
    logic [LANES-1:0] lane_ok;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_ok[g] = !sel[g] || (rd_word[8*g+7] == want7[g]);
    end

    assign all_ok = &lane_ok;
endmodule

// File: rtl/fl_phase_timer.sv
module fl_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/flash_pe_ctrl.sv
module flash_pe_ctrl
    import flash_pe_pkg::*;
#(
    parameter int ADDR_W   = 19,
    parameter int LANES    = 4,
    parameter int CNT_W    = 8,
    parameter int T_SET    = 1,
    parameter int T_WP     = 3,
    parameter int T_HOLD   = 3,
    parameter int T_OEH    = 1,
    parameter int T_ACC    = 4,
    parameter int POLL_MAX = 100000,
    localparam int LANE_W  = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int DATA_W  = 8 * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LANE_W-1:0] req_lane,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic              rsp_fail,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [DATA_W-1:0] fl_dout,
    output logic              fl_dout_en,
    input  logic [DATA_W-1:0] fl_din,
    output logic [LANES-1:0]  fl_cs_n,
    output logic [LANES-1:0]  fl_we_n,
    output logic              fl_oe_n
);
    localparam int POLL_W = $clog2(POLL_MAX + 1);

    fstate_e           state_q, state_d;
    fop_e              op_q, req_kind;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, cap_q;
    logic [LANES-1:0]  mask_q, want7_q, req_mask, req_bit7;
    logic [2:0]        step_q;
    logic [POLL_W-1:0] poll_q;
    logic              err_q;

    logic [ADDR_W-1:0] cmd_addr;
    logic [DATA_W-1:0] cmd_data;
    logic              cmd_last, tdone, all_ok, poll_last, accept;
    logic [CNT_W-1:0]  next_dur;

    always_comb begin
        unique case (req_op)
            3'd1:    req_kind = OP_PROG_WORD;
            3'd2:    req_kind = OP_PROG_BYTE;
            3'd3:    req_kind = OP_ERASE_SECT;
            3'd4:    req_kind = OP_ERASE_CHIP;
            default: req_kind = OP_READ;
        endcase
    end

    for (genvar g = 0; g < LANES; g++) begin : g_bit7
        assign req_bit7[g] = req_wdata[8*g+7];
    end

    assign req_mask  = (req_kind == OP_PROG_BYTE) ? (LANES'(1) << req_lane) : '1;
    assign accept    = (state_q == S_IDLE) && req_valid;
    assign poll_last = (poll_q == POLL_W'(POLL_MAX - 1));

    fl_cmd_table #(.ADDR_W(ADDR_W), .LANES(LANES)) u_cmd (
        .op       (op_q),
        .step     (step_q),
        .tgt_addr (addr_q),
        .wdata    (wdata_q),
        .bus_addr (cmd_addr),
        .bus_data (cmd_data),
        .last     (cmd_last)
    );

    fl_lane_status #(.LANES(LANES)) u_stat (
        .rd_word (cap_q),
        .sel     (mask_q),
        .want7   (want7_q),
        .all_ok  (all_ok)
    );

    function automatic logic [CNT_W-1:0] dur_of(fstate_e s);
        unique case (s)
            S_CMD_SET:   dur_of = CNT_W'(T_SET - 1);
            S_CMD_PULSE: dur_of = CNT_W'(T_WP - 1);
            S_CMD_HOLD:  dur_of = CNT_W'(T_HOLD - 1);
            S_OE_GAP:    dur_of = CNT_W'(T_OEH - 1);
            S_POLL_ACC,
            S_READ_ACC:  dur_of = CNT_W'(T_ACC - 1);
            default:     dur_of = '0;
        endcase
    endfunction

    assign next_dur = dur_of(state_d);

    fl_phase_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (state_d != state_q),
        .load_val (next_dur),
        .expired  (tdone)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:      if (req_valid)
                             state_d = (req_kind == OP_READ) ? S_READ_ACC : S_CMD_SET;
            S_CMD_SET:   if (tdone) state_d = S_CMD_PULSE;
            S_CMD_PULSE: if (tdone) state_d = S_CMD_HOLD;
            S_CMD_HOLD:  if (tdone) state_d = cmd_last ? S_OE_GAP : S_CMD_SET;
            S_OE_GAP:    if (tdone) state_d = S_POLL_ACC;
            S_POLL_ACC:  if (tdone) state_d = S_POLL_CHK;
            S_POLL_CHK:  state_d = (all_ok || poll_last) ? S_REPORT : S_POLL_ACC;
            S_READ_ACC:  if (tdone) state_d = S_REPORT;
            S_REPORT:    state_d = S_IDLE;
            default:     state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // operation context and capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OP_READ;
            addr_q  <= '0;
            wdata_q <= '0;
            mask_q  <= '0;
            want7_q <= '0;
            step_q  <= '0;
            poll_q  <= '0;
            err_q   <= 1'b0;
            cap_q   <= '0;
        end else begin
            if (accept) begin
                op_q    <= req_kind;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                mask_q  <= req_mask;
                want7_q <= ((req_kind == OP_ERASE_SECT) || (req_kind == OP_ERASE_CHIP))
                           ? '1 : req_bit7;
                step_q  <= '0;
                poll_q  <= '0;
                err_q   <= 1'b0;
            end
            if (state_q == S_CMD_HOLD && tdone)
                step_q <= step_q + 3'd1;
            if ((state_q == S_POLL_ACC || state_q == S_READ_ACC) && tdone)
                cap_q <= fl_din;
            if (state_q == S_POLL_CHK && !all_ok) begin
                poll_q <= poll_q + 1'b1;
                if (poll_last) err_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready  = 1'b0;
        rsp_done   = 1'b0;
        fl_cs_n    = '1;
        fl_we_n    = '1;
        fl_oe_n    = 1'b1;
        fl_dout_en = 1'b0;
        fl_addr    = addr_q;
        fl_dout    = cmd_data;
        unique case (state_q)
            S_IDLE:      req_ready = 1'b1;
            S_CMD_SET,
            S_CMD_HOLD: begin
                fl_cs_n    = ~mask_q;
                fl_addr    = cmd_addr;
                fl_dout_en = 1'b1;
            end
            S_CMD_PULSE: begin
                fl_cs_n    = ~mask_q;
                fl_we_n    = ~mask_q;
                fl_addr    = cmd_addr;
                fl_dout_en = 1'b1;
            end
            S_POLL_ACC: begin
                fl_cs_n = ~mask_q;
                fl_oe_n = 1'b0;
            end
            S_READ_ACC: begin
                fl_cs_n = '0;
                fl_oe_n = 1'b0;
            end
            S_REPORT:    rsp_done = 1'b1;
            default: ;
        endcase
    end

    assign rsp_fail  = rsp_done && err_q;
    assign rsp_rdata = cap_q;

endmodule

// File: rtl/fl_pe_checker.sv
module fl_pe_checker #(
    parameter int ADDR_W = 19,
    parameter int LANES  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_done,
    input logic              rsp_fail,
    input logic [ADDR_W-1:0] fl_addr,
    input logic [8*LANES-1:0] fl_dout,
    input logic              fl_dout_en,
    input logic [LANES-1:0]  fl_cs_n,
    input logic [LANES-1:0]  fl_we_n,
    input logic              fl_oe_n
);
    p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (req_ready && fl_oe_n && (fl_we_n == '1)));

    p_we_inside_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((~fl_we_n) & fl_cs_n) == '0);

    p_bus_stable_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((fl_we_n != '1) && $past(fl_we_n != '1)) |-> ($stable(fl_addr) && $stable(fl_dout)));

    p_no_we_in_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_oe_n |-> (fl_we_n == '1));

    p_fail_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fail |-> rsp_done);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> !req_ready);

    p_no_contention_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_oe_n |-> !fl_dout_en);
endmodule

bind flash_pe_ctrl fl_pe_checker #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .rsp_done   (rsp_done),
    .rsp_fail   (rsp_fail),
    .fl_addr    (fl_addr),
    .fl_dout    (fl_dout),
    .fl_dout_en (fl_dout_en),
    .fl_cs_n    (fl_cs_n),
    .fl_we_n    (fl_we_n),
    .fl_oe_n    (fl_oe_n)
);

// File: tb/flash_pe_ctrl_bench.sv
module flash_pe_ctrl_bench;
    localparam int AW = 19, NL = 4, DW = 32;
    localparam int TS = 1, TW = 3, TH = 2, TO = 2, TA = 4, PM = 6;
    localparam int BUSY = 10, STUCK = 200;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready;
    logic [2:0] req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0] req_lane = '0;
    logic [DW-1:0] req_wdata = '0;
    logic rsp_done, rsp_fail;
    logic [DW-1:0] rsp_rdata, fl_dout, fl_din;
    logic [AW-1:0] fl_addr;
    logic fl_dout_en, fl_oe_n;
    logic [NL-1:0] fl_cs_n, fl_we_n;

    always #10 clk = ~clk;

    flash_pe_ctrl #(.ADDR_W(AW), .LANES(NL), .T_SET(TS), .T_WP(TW), .T_HOLD(TH),
                    .T_OEH(TO), .T_ACC(TA), .POLL_MAX(PM)) u_flash_pe_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_lane(req_lane), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_fail(rsp_fail), .rsp_rdata(rsp_rdata),
        .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_dout_en(fl_dout_en), .fl_din(fl_din),
        .fl_cs_n(fl_cs_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n));

    int total = 0, bad = 0;

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // ---------------- behavioural byte-lane array ----------------
    logic [7:0] mem [int];
    int sst [NL], busy [NL], wcnt [NL], lowc [NL], setc [NL], holdc [NL];
    bit inhold [NL];
    logic [7:0] tgt7 [NL], lastd [NL];
    logic [AW-1:0] lasta [NL];
    logic [NL-1:0] stuck = '0;
    logic [NL-1:0] prev_we = '1;
    logic prev_oe = 1'b1;
    logic [AW-1:0] prev_addr = '0;
    logic [DW-1:0] prev_dout = '0;
    int perr = 0, e_we = 0, e_gap = 0, e_acc = 0, e_bus = 0, polls = 0, oelow = 0, oegap = 0;

    function automatic logic [7:0] rd_byte(int l, logic [AW-1:0] a);
        int k;
        k = (l << 20) | int'(a);
        return mem.exists(k) ? mem[k] : 8'hFF;
    endfunction

    task automatic start_busy(int l, logic b7);
        tgt7[l] = {7'd0, b7};
        busy[l] = stuck[l] ? STUCK : BUSY;
    endtask

    task automatic do_write(int l, logic [AW-1:0] a, logic [7:0] d);
        wcnt[l]++; lasta[l] = a; lastd[l] = d;
        case (sst[l])
            0: if (a == AW'(16'h5555) && d == 8'hAA) sst[l] = 1; else begin perr++; sst[l] = 0; end
            1: if (a == AW'(16'h2AAA) && d == 8'h55) sst[l] = 2; else begin perr++; sst[l] = 0; end
            2: if (a == AW'(16'h5555) && d == 8'hA0) sst[l] = 3;
               else if (a == AW'(16'h5555) && d == 8'h80) sst[l] = 4;
               else begin perr++; sst[l] = 0; end
            3: begin mem[(l << 20) | int'(a)] = d; start_busy(l, d[7]); sst[l] = 0; end
            4: if (a == AW'(16'h5555) && d == 8'hAA) sst[l] = 5; else begin perr++; sst[l] = 0; end
            5: if (a == AW'(16'h2AAA) && d == 8'h55) sst[l] = 6; else begin perr++; sst[l] = 0; end
            default: begin
                if (d == 8'h30) begin
                    foreach (mem[k]) if (((k >> 20) == l) && (((k >> 16) & 7) == int'(a[18:16]))) mem[k] = 8'hFF;
                    start_busy(l, 1'b1);
                end else if (a == AW'(16'h5555) && d == 8'h10) begin
                    foreach (mem[k]) if ((k >> 20) == l) mem[k] = 8'hFF;
                    start_busy(l, 1'b1);
                end else perr++;
                sst[l] = 0;
            end
        endcase
    endtask

    initial for (int l = 0; l < NL; l++) begin
        sst[l] = 0; busy[l] = 0; wcnt[l] = 0; lowc[l] = 0; setc[l] = 0; holdc[l] = 0; inhold[l] = 0;
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            fl_din <= '0;
        end else begin
            for (int l = 0; l < NL; l++) begin
                logic [7:0] cb, pb;
                cb = fl_dout[8*l +: 8];
                pb = prev_dout[8*l +: 8];
                if (busy[l] > 0) busy[l]--;
                if (inhold[l]) begin
                    if (!fl_cs_n[l] && fl_we_n[l] && fl_addr == lasta[l] && cb == lastd[l]) holdc[l]++;
                    else begin
                        if (holdc[l] < TH) e_we++;
                        inhold[l] = 0;
                    end
                end
                if (prev_we[l] && !fl_we_n[l]) begin
                    if (setc[l] < TS) e_we++;
                    lowc[l] = 1;
                end else if (!fl_we_n[l]) begin
                    lowc[l]++;
                    if (fl_addr != prev_addr || cb != pb) e_we++;
                end else if (!prev_we[l]) begin
                    if (lowc[l] != TW) e_we++;
                    do_write(l, prev_addr, pb);
                    holdc[l] = (!fl_cs_n[l] && fl_addr == prev_addr && cb == pb) ? 1 : 0;
                    inhold[l] = 1;
                end
                if (!fl_cs_n[l] && fl_we_n[l])
                    setc[l] = (fl_addr == prev_addr && cb == pb) ? setc[l] + 1 : 1;
                else if (fl_cs_n[l]) setc[l] = 0;
            end
            if (fl_we_n != '1) oegap = 0;
            else if (fl_oe_n && fl_cs_n == '1) oegap++;
            if (!fl_oe_n && fl_dout_en) e_bus++;
            if (!fl_oe_n) begin
                if (prev_oe) begin
                    polls++;
                    if (oegap < TO) e_gap++;
                    oelow = 1;
                end else oelow++;
            end else if (!prev_oe) begin
                if (oelow != TA) e_acc++;
            end
            for (int l = 0; l < NL; l++) begin
                if (!fl_cs_n[l] && !fl_oe_n)
                    fl_din[8*l +: 8] <= (busy[l] > 0) ? {~tgt7[l][0], 7'h2A} : rd_byte(l, fl_addr);
                else
                    fl_din[8*l +: 8] <= 8'h00;
            end
            prev_we   = fl_we_n;
            prev_oe   = fl_oe_n;
            prev_addr = fl_addr;
            prev_dout = fl_dout;
        end
    end

    // ---------------- request driver ----------------
    logic r_fail;
    logic [31:0] r_data;

    task automatic run_op(input logic [2:0] op, input logic [AW-1:0] a, input logic [1:0] ln,
                          input logic [31:0] d);
        int guard;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_lane = ln; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R10 ready low while busy", {31'd0, req_ready}, 32'd0);
        guard = 0;
        while (!rsp_done && guard < 2000) begin @(negedge clk); guard++; end
        chk(rsp_done == 1'b1, "R10 operation completes", {31'd0, rsp_done}, 32'd1);
        r_fail = rsp_fail; r_data = rsp_rdata;
        @(negedge clk);
        chk(rsp_done == 1'b0, "R10 done single cycle", {31'd0, rsp_done}, 32'd0);
    endtask

    function automatic logic [31:0] lanes_last();
        return {lastd[3], lastd[2], lastd[1], lastd[0]};
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int w0 [NL];
        logic [31:0] acc, d, s5;
        logic [AW-1:0] a;
        int p0;
        repeat (4) @(negedge clk);
        chk(fl_cs_n == '1 && fl_we_n == '1 && fl_oe_n, "R1 bus idle in reset", {fl_cs_n, fl_we_n}, 32'hFF);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !rsp_done, "R1 ready after reset", {30'd0, req_ready, rsp_done}, 32'd2);
        chk(fl_cs_n == '1 && fl_we_n == '1 && fl_oe_n, "R1 bus idle after reset", {fl_cs_n, fl_we_n}, 32'hFF);

        // R2 / R7 / R9: word program sweep
        for (int i = 0; i < 6; i++) begin
            d = (i == 0) ? 32'h807F00FF : 32'h9E3779B9 * (i + 1);
            a = AW'(i * 4099 + 17);
            for (int l = 0; l < NL; l++) w0[l] = wcnt[l];
            run_op(3'd1, a, 2'd0, d);
            chk(r_fail == 1'b0, "R7 program succeeds", {31'd0, r_fail}, 32'd0);
            for (int l = 0; l < NL; l++)
                chk(wcnt[l] - w0[l] == 4, "R2 four writes per lane", wcnt[l] - w0[l], 32'd4);
            chk(lanes_last() == d, "R2 data cycle bytes", lanes_last(), d);
            chk(lasta[0] == a, "R2 data cycle address", 32'(lasta[0]), 32'(a));
            run_op(3'd0, a, 2'd0, 32'd0);
            chk(r_data == d && !r_fail, "R9 readback", r_data, d);
        end
        chk(perr == 0, "R2 unlock order", perr, 32'd0);

        // R3: byte program on each lane
        a = AW'(19'h0ABC0);
        acc = 32'hFFFFFFFF;
        for (int l = 0; l < NL; l++) begin
            logic [7:0] b;
            b = (8'h11 * 8'(l + 1)) ^ ((l % 2 == 1) ? 8'h80 : 8'h00);
            for (int k = 0; k < NL; k++) w0[k] = wcnt[k];
            run_op(3'd2, a, 2'(l), 32'(b) << (8 * l));
            acc[8*l +: 8] = b;
            chk(r_fail == 1'b0, "R3 byte program succeeds", {31'd0, r_fail}, 32'd0);
            for (int k = 0; k < NL; k++)
                chk(wcnt[k] - w0[k] == ((k == l) ? 4 : 0), "R3 lane strobes", wcnt[k] - w0[k],
                    (k == l) ? 32'd4 : 32'd0);
            run_op(3'd0, a, 2'd0, 32'd0);
            chk(r_data == acc, "R3 other lanes untouched", r_data, acc);
        end

        // R4: sector erase
        s5 = 32'h5A5AC3C3;
        run_op(3'd1, AW'(19'h30123), 2'd0, 32'h01020304);
        run_op(3'd1, AW'(19'h50456), 2'd0, s5);
        for (int l = 0; l < NL; l++) w0[l] = wcnt[l];
        run_op(3'd3, AW'(19'h37777), 2'd0, 32'd0);
        chk(r_fail == 1'b0, "R4 sector erase completes", {31'd0, r_fail}, 32'd0);
        chk(wcnt[1] - w0[1] == 6, "R4 six erase writes", wcnt[1] - w0[1], 32'd6);
        chk(lasta[2] == AW'(19'h37777) && lastd[2] == 8'h30, "R4 sector command cycle",
            {lasta[2], lastd[2]}, {AW'(19'h37777), 8'h30});
        run_op(3'd0, AW'(19'h30123), 2'd0, 32'd0);
        chk(r_data == 32'hFFFFFFFF, "R4 erased sector reads FF", r_data, 32'hFFFFFFFF);
        run_op(3'd0, AW'(19'h50456), 2'd0, 32'd0);
        chk(r_data == s5, "R4 other sector kept", r_data, s5);

        // R10: an array-erase request held while busy must be ignored
        for (int l = 0; l < NL; l++) w0[l] = wcnt[l];
        @(negedge clk);
        req_valid = 1'b1; req_op = 3'd1; req_addr = AW'(19'h60010); req_wdata = 32'h13572468;
        @(negedge clk);
        req_op = 3'd4;
        repeat (5) @(negedge clk);
        chk(req_ready == 1'b0, "R10 not ready mid operation", {31'd0, req_ready}, 32'd0);
        req_valid = 1'b0;
        while (!rsp_done) @(negedge clk);
        @(negedge clk);
        chk(wcnt[0] - w0[0] == 4, "R10 busy request ignored", wcnt[0] - w0[0], 32'd4);
        run_op(3'd0, AW'(19'h50456), 2'd0, 32'd0);
        chk(r_data == s5, "R10 no erase happened", r_data, s5);

        // R8: every lane stuck busy
        stuck = 4'hF;
        p0 = polls;
        run_op(3'd1, AW'(19'h00777), 2'd0, 32'h11223344);
        chk(r_fail == 1'b1, "R8 timeout flagged", {31'd0, r_fail}, 32'd1);
        chk(polls - p0 == PM, "R8 poll count", polls - p0, PM);
        repeat (STUCK + 20) @(negedge clk);

        // R7: one lane stuck blocks success
        stuck = 4'b0100;
        run_op(3'd1, AW'(19'h00778), 2'd0, 32'h80808080);
        chk(r_fail == 1'b1, "R7 single busy lane blocks", {31'd0, r_fail}, 32'd1);
        repeat (STUCK + 20) @(negedge clk);
        stuck = '0;

        // R4: array erase
        for (int l = 0; l < NL; l++) w0[l] = wcnt[l];
        run_op(3'd4, AW'(19'h12345), 2'd0, 32'd0);
        chk(r_fail == 1'b0, "R4 array erase completes", {31'd0, r_fail}, 32'd0);
        chk(wcnt[3] - w0[3] == 6 && lasta[3] == AW'(16'h5555) && lastd[3] == 8'h10,
            "R4 array command cycle", {24'(lasta[3]), lastd[3]}, {24'h005555, 8'h10});
        run_op(3'd0, AW'(19'h50456), 2'd0, 32'd0);
        chk(r_data == 32'hFFFFFFFF, "R4 array erased", r_data, 32'hFFFFFFFF);
        run_op(3'd0, AW'(17), 2'd0, 32'd0);
        chk(r_data == 32'hFFFFFFFF, "R4 array erased low word", r_data, 32'hFFFFFFFF);

        chk(perr == 0, "R4 erase unlock order", perr, 32'd0);
        chk(e_we == 0, "R5 pulse width setup hold", e_we, 32'd0);
        chk(e_gap == 0, "R6 output enable recovery", e_gap, 32'd0);
        chk(e_acc == 0, "R9 access time", e_acc, 32'd0);
        chk(e_bus == 0, "R11 bus contention", e_bus, 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule